// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Polarity

This block is a memory-mapped general-purpose I/O port of up to 32 pins. Software programs which pins are driven, what value they carry, and how each of the low sixteen pins raises an interrupt. The register bus is simple: an address, a write strobe with write data, and combinational read data. Pin inputs pass through a two-stage synchroniser before they reach the input readback or the interrupt logic.

The stored output value of a pin also selects the polarity of that pin's interrupt. When the output bit is 0 the pin reacts to a rising edge or a high level. When it is 1 the pin reacts to a falling edge or a low level. A per-pin mode bit selects detection on both edges instead. Each interrupt-capable pin drives its own active-high line to an external interrupt controller. There is no status or acknowledge register. A build parameter chooses edge detection (one-clock pulses) or level detection (the line follows the polarity-adjusted input).

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, the direction, output and mode registers are zero. Every pin then reads as an input, every pin_out bit is 0, and no interrupt line is high.
- R2: Register offsets: 0x00 direction (read/write), 0x08 synchronised input (read only), 0x10 output value (read/write), 0x18 set strobe, 0x20 clear strobe, 0x30 interrupt mode (read/write). The set and clear offsets and any other unmapped offset read as 0.
- R3: Writing to 0x18 sets every output bit whose write-data bit is 1. Writing to 0x20 clears every such bit. Bits written as 0 are left unchanged.
- R4: pin_oe equals the direction register and pin_out equals the output register, from the clock edge after the write.
- R5: The input readback at 0x08 shows a pin change two clock edges after the change is presented on pin_in.
- R6: Edge build, mode bit 0, output bit 0: a synchronised rising edge on pin i (i < 16) gives a high on irq[i] for exactly one clock. A falling edge gives nothing.
- R7: Edge build, mode bit 0, output bit 1: a synchronised falling edge gives a one-clock pulse. A rising edge gives nothing.
- R8: With mode bit 1, both edges of pin i give a one-clock pulse on irq[i], whatever the output bit.
- R9: Level build, mode bit 0: irq[i] equals the synchronised pin XOR output bit i. It is active high for both polarities. With mode bit 1 the line pulses on both edges as in R8.
- R10: Only pins 0 to 15 have interrupt lines. Pins 16 to 31 never affect irq.
- R11: In the edge build, changing a pin's output (polarity) bit while the pin is stable produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables (1 = driven) |
| irq | output | 16 | Per-pin active-high interrupt lines |

## Verification
Two functions can fall in the same cycle: a write that flips a pin's output bit, which is also its polarity, and a synchronised edge on that same pin. The bench provokes the collision directly. It sets and clears the polarity of a pin held stable and checks that the edge build stays silent while the level build follows. Random traffic then mixes writes to the output, set and clear registers with pin toggles, so polarity changes land on edge cycles. Every cycle the interrupt lines are compared against a bench model that evaluates both the current and the previous sample with the current polarity.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS     = 32,
  parameter int NIRQ      = 16,
  parameter int AW        = 6,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NIRQ-1:0]  irq
);
  localparam logic [AW-1:0] OFF_DIR  = AW'(6'h00);
  localparam logic [AW-1:0] OFF_IN   = AW'(6'h08);
  localparam logic [AW-1:0] OFF_OUT  = AW'(6'h10);
  localparam logic [AW-1:0] OFF_SET  = AW'(6'h18);
  localparam logic [AW-1:0] OFF_CLR  = AW'(6'h20);
  localparam logic [AW-1:0] OFF_MODE = AW'(6'h30);

  logic [NPINS-1:0] dir_q, out_q, mode_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q;
  logic [NPINS-1:0] wd;

  assign wd = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mode_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_DIR:  dir_q  <= wd;
        OFF_OUT:  out_q  <= wd;
        OFF_SET:  out_q  <= out_q | wd;
        OFF_CLR:  out_q  <= out_q & ~wd;
        OFF_MODE: mode_q <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_DIR:  bus_rdata[NPINS-1:0] = dir_q;
      OFF_IN:   bus_rdata[NPINS-1:0] = s2_q;
      OFF_OUT:  bus_rdata[NPINS-1:0] = out_q;
      OFF_MODE: bus_rdata[NPINS-1:0] = mode_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;

  logic [NIRQ-1:0] cur, prv, both, one;
  assign cur  = s2_q[NIRQ-1:0] ^ out_q[NIRQ-1:0];
  assign prv  = s3_q[NIRQ-1:0] ^ out_q[NIRQ-1:0];
  assign both = s2_q[NIRQ-1:0] ^ s3_q[NIRQ-1:0];

  generate
    if (EDGE_MODE) begin : g_edge
      assign one = cur & ~prv;
    end else begin : g_level
      assign one = cur;
    end
  endgenerate

  assign irq = (mode_q[NIRQ-1:0] & both) | (~mode_q[NIRQ-1:0] & one);
endmodule

module gpio_irq_ctrl_chk #(
  parameter int NPINS     = 32,
  parameter int NIRQ      = 16,
  parameter int AW        = 6,
  parameter bit EDGE_MODE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NIRQ-1:0]  irq,
  input logic [NPINS-1:0] mode_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0));

  assert_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h00)) |=> pin_oe == $past(bus_wdata[NPINS-1:0]));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h18)) |=>
      (pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h20)) |=>
      (pin_out & $past(bus_wdata[NPINS-1:0])) == '0);

  assert_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && bus_addr == AW'(6'h08)) |->
      bus_rdata[NPINS-1:0] == $past(pin_in, 2));

  assert_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (EDGE_MODE && age == 2'd3) |->
      (irq & ~($past(pin_in[NIRQ-1:0], 2) ^ $past(pin_in[NIRQ-1:0], 3))) == '0);

  assert_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!EDGE_MODE && age == 2'd3) |->
      ((irq ^ $past(pin_in[NIRQ-1:0], 2) ^ pin_out[NIRQ-1:0]) & ~mode_q[NIRQ-1:0]) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NPINS(NPINS), .NIRQ(NIRQ), .AW(AW), .EDGE_MODE(EDGE_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .mode_q(mode_q)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] rd_e, rd_l, pout, poe, pout_l, poe_l;
  logic [15:0] irq_e, irq_l;
  int total = 0, bad = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.EDGE_MODE(1'b1)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_e), .pin_in(pin_in),
    .pin_out(pout), .pin_oe(poe), .irq(irq_e));

  gpio_irq_ctrl #(.EDGE_MODE(1'b0)) i_gpio_irq_ctrl_lvl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pin_in),
    .pin_out(pout_l), .pin_oe(poe_l), .irq(irq_l));

  logic [31:0] m_dir, m_out, m_mode, p1, p2, p3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= '0; m_out <= '0; m_mode <= '0; p1 <= '0; p2 <= '0; p3 <= '0;
    end else begin
      p1 <= pin_in; p2 <= p1; p3 <= p2;
      if (bus_wr) case (bus_addr)
        6'h00: m_dir  <= bus_wdata;
        6'h10: m_out  <= bus_wdata;
        6'h18: m_out  <= m_out | bus_wdata;
        6'h20: m_out  <= m_out & ~bus_wdata;
        6'h30: m_mode <= bus_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    case (a)
      6'h00: return m_dir;
      6'h08: return p2;
      6'h10: return m_out;
      6'h30: return m_mode;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_irq(bit edge_build);
    logic [15:0] c, p, b;
    c = p2[15:0] ^ m_out[15:0];
    p = p3[15:0] ^ m_out[15:0];
    b = p2[15:0] ^ p3[15:0];
    return (m_mode[15:0] & b) | (~m_mode[15:0] & (edge_build ? (c & ~p) : c));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    check("R2 R5 rdata", rd_e, exp_rd(bus_addr));
    check("R2 R5 rdata lvl", rd_l, exp_rd(bus_addr));
    check("R4 pins", {pout ^ m_out} | {poe ^ m_dir}, 32'h0);
    check("R6 R7 R8 R10 R11 irq edge", {16'h0, irq_e}, {16'h0, exp_irq(1'b1)});
    check("R9 R10 irq level", {16'h0, irq_l}, {16'h0, exp_irq(1'b0)});
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 oe reset", poe, 32'h0);
    check("R1 out reset", pout, 32'h0);
    check("R1 irq reset", {irq_e, irq_l}, 32'h0);
    #1 rst_n = 1'b1;
    tick();
    mon_en = 1'b1;
    foreach (bus_addr[i]) begin end
    for (int a = 0; a < 64; a += 8) begin
      bus_addr = 6'(a); @(negedge clk);
      check("R1 R2 reg reset", rd_e, 32'h0);
      #1;
    end
    // R2 readback and unmapped read
    wr(6'h00, 32'hA5A5_0F0F); wr(6'h30, 32'h0000_0000);
    bus_addr = 6'h00; @(negedge clk); check("R2 dir read", rd_e, 32'hA5A5_0F0F); #1;
    bus_addr = 6'h28; @(negedge clk); check("R2 unmapped", rd_e, 32'h0); #1;
    // R3 set / clear
    wr(6'h10, 32'h0000_00F0);
    wr(6'h18, 32'h0000_0003);
    bus_addr = 6'h10; @(negedge clk); check("R3 set", rd_e, 32'h0000_00F3); #1;
    wr(6'h20, 32'h0000_0030);
    @(negedge clk); check("R3 clear", pout, 32'h0000_00C3);
    bus_addr = 6'h18; check("R2 set reads zero", rd_e, 32'h0); #1;
    wr(6'h10, 32'h0);
    repeat (3) tick();
    // R5 synchroniser latency and R6 rising pulse
    bus_addr = 6'h08;
    pin_in = 32'h0000_0001;
    @(negedge clk); check("R5 one edge", rd_e, 32'h0); check("R6 no early", {16'h0, irq_e}, 32'h0); #1;
    @(negedge clk); check("R5 two edges", rd_e, 32'h1); check("R6 pulse", {16'h0, irq_e}, 32'h1);
    check("R9 level high", {16'h0, irq_l}, 32'h1); #1;
    @(negedge clk); check("R6 one clock", {16'h0, irq_e}, 32'h0); #1;
    // R11 polarity flip with stable pin
    wr(6'h18, 32'h0000_0001);
    @(negedge clk); check("R11 no pulse", {16'h0, irq_e}, 32'h0);
    check("R9 level follows polarity", {16'h0, irq_l}, 32'h0); #1;
    // R7 falling pulse
    pin_in = 32'h0;
    tick();
    @(negedge clk); check("R7 fall pulse", {16'h0, irq_e}, 32'h1);
    check("R9 low level active high", {16'h0, irq_l}, 32'h1); #1;
    wr(6'h20, 32'h0000_0001);
    // R8 both edges, R10 upper pins
    wr(6'h30, 32'h0000_0004);
    repeat (3) tick();
    pin_in = 32'h0001_0004;
    tick();
    @(negedge clk); check("R8 rise", {16'h0, irq_e}, 32'h4); check("R10 upper", {16'h0, irq_l}, 32'h4); #1;
    pin_in = 32'h0000_0000;
    tick();
    @(negedge clk); check("R8 fall", {16'h0, irq_e}, 32'h4); #1;
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [5:0] a;
        case ($urandom_range(0, 6))
          0: a = 6'h00; 1: a = 6'h10; 2: a = 6'h18; 3: a = 6'h20;
          4: a = 6'h30; 5: a = 6'h08; default: a = 6'h3C;
        endcase
        wr(a, $urandom());
      end else if (op < 7) begin
        pin_in = pin_in ^ ($urandom() & $urandom());
        tick();
      end else begin
        bus_addr = 6'($urandom_range(0, 7) * 8);
        tick();
      end
    end
    mon_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule